// File: doc/BRIEF.md
# Sync Activity and Polarity Monitor

This block sits in the pixel-clock domain of a video front end and watches five sync-related lines: horizontal sync, the direct vertical sync input, sync-on-green, coast, and the vertical sync produced by a sync separator. Each raw line first passes through a two-flop synchronizer. For the horizontal sync, vertical sync, sync-on-green and coast lines the block reports whether the line is toggling. A line held steadily high or low for a full timeout window counts as idle.

For horizontal sync, coast and the chosen vertical sync output, the block measures how long the line stays high and how long it stays low in each period. The shorter level is taken as the active level. A polarity result only changes after two consecutive measurements agree.

The vertical sync output comes either from the direct input or from the separator. In automatic mode the direct input is used while it is toggling, and the separator otherwise. Two software control bits can force the choice. All results are gathered in one registered, read-only status byte.

Top module: `sync_status_monitor`

## Requirements
- R1: A line that keeps toggling drives its activity bit to 1. Status bit 6 is horizontal sync, bit 5 is coast, bit 4 is the direct vertical sync input and bit 1 is sync-on-green.
- R2: A line held at one constant level clears its activity bit to 0 once 2^ACT_TO_W clock cycles pass with no edge. While less than that time has passed since the last edge, the bit stays 1.
- R3: The status byte is laid out as follows: bit 7 horizontal sync polarity, bit 6 horizontal sync activity, bit 5 coast activity, bit 4 vertical sync activity, bit 3 vertical sync source, bit 2 vertical sync output polarity, bit 1 sync-on-green activity, bit 0 coast polarity.
- R4: With `force_src_i` at 0, status bit 3 is the inverse of status bit 4. A value of 0 selects the direct vertical sync input and 1 selects the separator output.
- R5: With `force_src_i` at 1, status bit 3 equals `prio_sep_i`, whatever the activity.
- R6: Horizontal sync polarity (bit 7) is 1 (positive) when the high phase is shorter than the low phase. It is 0 (negative) when the high phase is longer or the two phases are equal.
- R7: Vertical sync output polarity (bit 2) is measured on the source currently selected by bit 3. It is 1 for active high (short high phase) and 0 for active low.
- R8: Coast polarity (bit 0) is 1 (positive) when the high phase of coast is shorter than its low phase, and 0 otherwise.
- R9: A polarity bit changes only after two consecutive complete-period measurements give the same new value. A single differing period leaves it unchanged.
- R10: While `rst` is high the status byte reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Direct vertical sync, asynchronous |
| sog_i | input | 1 | Sliced sync-on-green, asynchronous |
| coast_i | input | 1 | Coast input, asynchronous |
| vsync_sep_i | input | 1 | Vertical sync from the sync separator |
| prio_sep_i | input | 1 | Source value applied when forcing (1 = separator) |
| force_src_i | input | 1 | 1 forces the vertical sync source to `prio_sep_i` |
| status_o | output | 8 | Registered status byte (layout in R3) |

## Verification
The assertions check three things on every cycle. An activity flag rises only after an edge and falls only after a full idle window. A polarity bit moves only on a measurement strobe. Bit 3 follows the automatic or forced selection rule one clock after its inputs. The bench's scenarios are needed for the parts that depend on many cycles of history. These are the polarity result for each ratio of high to low phase, rejection of a single odd period, and the clear that follows a line held high or low. They also include polarity following the vertical sync source when the selection switches between the direct input and the separator.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int ST_HPOL = 7;
  localparam int ST_HACT = 6;
  localparam int ST_CACT = 5;
  localparam int ST_VACT = 4;
  localparam int ST_VSRC = 3;
  localparam int ST_VPOL = 2;
  localparam int ST_SACT = 1;
  localparam int ST_CPOL = 0;

  // index of each line inside the synchronized bus
  localparam int LN_HS   = 0;
  localparam int LN_VS   = 1;
  localparam int LN_SOG  = 2;
  localparam int LN_CST  = 3;
  localparam int LN_VSEP = 4;
  localparam int NUM_LINES = 5;

  typedef enum logic {
    SRC_DIRECT    = 1'b0,
    SRC_SEPARATOR = 1'b1
  } vs_src_e;
endpackage

// File: rtl/ssm_sync.sv
module ssm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ssm_activity.sv
module ssm_activity #(
  parameter int TO_W = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic act_o
);
  logic            prev_q;
  logic            primed_q;
  logic            act_q;
  logic [TO_W-1:0] idle_q;
  logic            edge_w;

  assign edge_w = primed_q && (sig_i != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
      act_q    <= 1'b0;
      idle_q   <= '0;
    end else begin
      prev_q   <= sig_i;
      primed_q <= 1'b1;
      if (edge_w) begin
        idle_q <= '0;
        act_q  <= 1'b1;
      end else if (&idle_q) begin
        act_q  <= 1'b0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign act_o = act_q;

  p_rise_needs_edge_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> $past(edge_w));

  p_fall_after_window_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q) |-> ($past(&idle_q) && !$past(edge_w)));
endmodule

// File: rtl/ssm_polarity.sv
module ssm_polarity #(
  parameter int LEN_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic pol_o
);
  logic             prev_q;
  logic             primed_q;
  logic             started_q;
  logic             hi_ok_q;
  logic [LEN_W-1:0] hi_cnt_q;
  logic [LEN_W-1:0] lo_cnt_q;
  logic [LEN_W-1:0] hi_len_q;
  logic             last_q;
  logic             have_last_q;
  logic             pol_q;
  logic             rise_w;
  logic             fall_w;
  logic             meas_stb_w;
  logic             meas_val_w;

  assign rise_w     = primed_q &&  sig_i && !prev_q;
  assign fall_w     = primed_q && !sig_i &&  prev_q;
  assign meas_stb_w = rise_w && hi_ok_q;
  // shorter high phase means the line pulses high
  assign meas_val_w = (hi_len_q < lo_cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q      <= 1'b0;
      primed_q    <= 1'b0;
      started_q   <= 1'b0;
      hi_ok_q     <= 1'b0;
      hi_cnt_q    <= '0;
      lo_cnt_q    <= '0;
      hi_len_q    <= '0;
      last_q      <= 1'b0;
      have_last_q <= 1'b0;
      pol_q       <= 1'b0;
    end else begin
      prev_q   <= sig_i;
      primed_q <= 1'b1;
      if (rise_w) begin
        started_q <= 1'b1;
        hi_cnt_q  <= {{(LEN_W-1){1'b0}}, 1'b1};
      end else if (fall_w) begin
        started_q <= 1'b1;
        hi_ok_q   <= started_q;
        hi_len_q  <= hi_cnt_q;
        lo_cnt_q  <= {{(LEN_W-1){1'b0}}, 1'b1};
      end else if (sig_i) begin
        if (!(&hi_cnt_q)) hi_cnt_q <= hi_cnt_q + 1'b1;
      end else begin
        if (!(&lo_cnt_q)) lo_cnt_q <= lo_cnt_q + 1'b1;
      end
      if (meas_stb_w) begin
        last_q      <= meas_val_w;
        have_last_q <= 1'b1;
        if (have_last_q && (last_q == meas_val_w)) pol_q <= meas_val_w;
      end
    end
  end

  assign pol_o = pol_q;

  p_pol_on_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(pol_q) |-> $past(meas_stb_w));

  p_pol_needs_history_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(pol_q) |-> $past(have_last_q));
endmodule

// File: rtl/sync_status_monitor.sv
module sync_status_monitor
  import ssm_pkg::*;
#(
  parameter int ACT_TO_W    = 20,
  parameter int LEN_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hsync_i,
  input  logic       vsync_i,
  input  logic       sog_i,
  input  logic       coast_i,
  input  logic       vsync_sep_i,
  input  logic       prio_sep_i,
  input  logic       force_src_i,
  output logic [7:0] status_o
);
  localparam int NUM_ACT = 4;
  localparam int NUM_POL = 3;

  logic [NUM_LINES-1:0] raw_w;
  logic [NUM_LINES-1:0] sync_w;
  logic [NUM_ACT-1:0]   act_w;
  logic [NUM_POL-1:0]   pol_in_w;
  logic [NUM_POL-1:0]   pol_w;
  vs_src_e              src_w;
  logic                 vs_out_w;
  logic [7:0]           status_d;
  logic [7:0]           status_q;

  always_comb begin
    raw_w          = '0;
    raw_w[LN_HS]   = hsync_i;
    raw_w[LN_VS]   = vsync_i;
    raw_w[LN_SOG]  = sog_i;
    raw_w[LN_CST]  = coast_i;
    raw_w[LN_VSEP] = vsync_sep_i;
  end

  ssm_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_w),
    .q_o (sync_w)
  );

  // activity on hsync, vsync input, sog, coast (indices 0..3 of the bus)
  for (genvar g = 0; g < NUM_ACT; g++) begin : g_act
    ssm_activity #(.TO_W(ACT_TO_W)) u_act (
      .clk   (clk),
      .rst   (rst),
      .sig_i (sync_w[g]),
      .act_o (act_w[g])
    );
  end

  always_comb begin
    if (force_src_i) src_w = vs_src_e'(prio_sep_i);
    else             src_w = act_w[LN_VS] ? SRC_DIRECT : SRC_SEPARATOR;
  end

  assign vs_out_w = (src_w == SRC_SEPARATOR) ? sync_w[LN_VSEP] : sync_w[LN_VS];

  assign pol_in_w = {sync_w[LN_CST], vs_out_w, sync_w[LN_HS]};

  for (genvar g = 0; g < NUM_POL; g++) begin : g_pol
    ssm_polarity #(.LEN_W(LEN_W)) u_pol (
      .clk   (clk),
      .rst   (rst),
      .sig_i (pol_in_w[g]),
      .pol_o (pol_w[g])
    );
  end

  always_comb begin
    status_d          = '0;
    status_d[ST_HPOL] = pol_w[0];
    status_d[ST_HACT] = act_w[LN_HS];
    status_d[ST_CACT] = act_w[LN_CST];
    status_d[ST_VACT] = act_w[LN_VS];
    status_d[ST_VSRC] = src_w;
    status_d[ST_VPOL] = pol_w[1];
    status_d[ST_SACT] = act_w[LN_SOG];
    status_d[ST_CPOL] = pol_w[2];
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  assign status_o = status_q;

  p_auto_src_r4: assert property (@(posedge clk) disable iff (rst)
    !force_src_i |=> (status_o[ST_VSRC] == !$past(act_w[LN_VS])));

  p_force_src_r5: assert property (@(posedge clk) disable iff (rst)
    force_src_i |=> (status_o[ST_VSRC] == $past(prio_sep_i)));

  p_act_tracks_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_o[ST_VACT] == $past(act_w[LN_VS])));
endmodule

// File: tb/test_sync_status_monitor.sv
module test_sync_status_monitor;
  localparam int TO_W = 6;
  localparam int WIN  = 1 << TO_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] drv = '0;
  logic       prio = 1'b0;
  logic       force_src = 1'b0;
  logic [7:0] status;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  sync_status_monitor #(.ACT_TO_W(TO_W), .LEN_W(8), .SYNC_STAGES(2)) i_sync_status_monitor (
    .clk         (clk),
    .rst         (rst),
    .hsync_i     (drv[0]),
    .vsync_i     (drv[1]),
    .sog_i       (drv[2]),
    .coast_i     (drv[3]),
    .vsync_sep_i (drv[4]),
    .prio_sep_i  (prio),
    .force_src_i (force_src),
    .status_o    (status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n periods on line idx: high for hi cycles, then low for lo cycles
  task automatic train(input int idx, input int hi, input int lo, input int n);
    for (int p = 0; p < n; p++) begin
      drv[idx] = 1'b1;
      repeat (hi) @(negedge clk);
      drv[idx] = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  initial begin
    int lens [4] = '{2, 3, 5, 9};
    idle(4);
    chk("R10 status in reset", status, 0);
    rst = 1'b0;
    idle(3);
    chk("R4 idle vsync selects separator", status[3], 1);

    // polarity sweep on hsync and coast with mirrored duty
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != b) begin
          fork
            train(0, lens[a], lens[b], 6);
            train(3, lens[b], lens[a], 6);
          join
          idle(4);
          chk("R6 hsync polarity", status[7], int'(lens[a] < lens[b]));
          chk("R8 coast polarity", status[0], int'(lens[b] < lens[a]));
          chk("R1 hsync activity", status[6], 1);
          chk("R1 coast activity", status[5], 1);
        end
      end
    end

    // R9: a single odd period must not flip polarity
    train(0, 2, 9, 4);
    idle(4);
    chk("R9 baseline positive", status[7], 1);
    train(0, 9, 2, 1);
    drv[0] = 1'b1;
    idle(2);
    drv[0] = 1'b0;
    idle(6);
    chk("R9 single period ignored", status[7], 1);
    train(0, 9, 2, 4);
    idle(4);
    chk("R9 repeated period flips", status[7], 0);

    // R2: all lines quiet low for longer than the window
    idle(3 * WIN);
    chk("R2 hsync idle", status[6], 0);
    chk("R2 coast idle", status[5], 0);
    chk("R2 vsync idle", status[4], 0);
    chk("R2 sog idle", status[1], 0);
    chk("R3 full status byte", status, 8'h09);

    // sog: toggle, then hold high
    train(2, 3, 4, 4);
    idle(2);
    chk("R1 sog activity", status[1], 1);
    drv[2] = 1'b1;
    idle(WIN / 2);
    chk("R2 sog inside window", status[1], 1);
    idle(2 * WIN);
    chk("R2 sog held high", status[1], 0);
    drv[2] = 1'b0;

    // source selection sweep
    for (int v = 0; v < 2; v++) begin
      if (v == 1) train(1, 3, 4, 4);
      else        idle(2 * WIN);
      for (int ov = 0; ov < 2; ov++) begin
        for (int pr = 0; pr < 2; pr++) begin
          force_src = 1'(ov);
          prio = 1'(pr);
          idle(2);
          chk("R1 vsync activity", status[4], v);
          if (ov == 1) chk("R5 forced source", status[3], pr);
          else         chk("R4 automatic source", status[3], 1 - v);
        end
      end
    end

    // R7: vsync output polarity follows the selected source
    force_src = 1'b0;
    train(1, 2, 9, 6);
    idle(4);
    chk("R7 direct vsync active high", status[2], 1);
    force_src = 1'b1;
    prio = 1'b1;
    train(4, 9, 2, 6);
    idle(4);
    chk("R7 separator active low", status[2], 0);
    chk("R5 separator forced", status[3], 1);
    prio = 1'b0;
    train(1, 2, 9, 6);
    idle(4);
    chk("R7 forced direct active high", status[2], 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule